// File: doc/BRIEF.md
# Multi-Port Register File with Same-Cycle Forwarding

This block is the architectural register file of a wide-issue signal-processing core. It holds a small array of words and serves many readers and writers in every clock cycle. Each write port carries an enable, an entry address and a data word. Each read port carries an entry address and returns a data word combinationally.

A value presented on a write port is visible on any read port that addresses the same entry in that same cycle. A forwarding path steers the incoming write data around the array to do this. The array commits the value at the next rising clock edge. When several enabled writers target one entry in a cycle, a fixed priority settles the conflict, and the forwarding path applies the same priority.

Addresses reach the array through a two-level decoder. Low and high address groups are predecoded separately, and each wordline is then formed as the AND of one line from each group. The array holds each word in complemented form, and the read side restores the true value.

Top module: `rf_mp_top`

## Requirements
- R1: While rst_ni is low the array is cleared asynchronously, and after release every entry reads as zero on every read port until it is written.
- R2: A word written through an enabled port at a rising edge is returned by any read of that entry in later cycles, until the entry is written again.
- R3: A read of an entry that an enabled write port targets in the current cycle returns that port's write data in the same cycle, before the clock edge.
- R4: When more than one enabled write port targets one entry in a cycle, the port with the highest index wins. Its data is both forwarded in that cycle and stored at the edge.
- R5: A write port whose enable bit is low changes no entry and forwards nothing, whatever its address and data.
- R6: All read ports work independently in the same cycle. Several ports reading one entry return identical data.
- R7: An entry that no enabled port writes in a cycle keeps its contents across the edge.
- R8: Each address selects exactly one entry. The low 2 address bits are predecoded to 4 lines and the remaining bits to 8 lines, and wordline e is the AND of low line e%4 and high line e/4.
- R9: The cells hold the bitwise complement of the logical word. Read data equals the logical word written, including the all-zero and all-one patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the array commits at the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | NUM_WR (6) | Write enable, bit w for write port w |
| waddr_i | input | NUM_WR*ADDR_W (30) | Write addresses, port w at bits [w*ADDR_W +: ADDR_W] |
| wdata_i | input | NUM_WR*DATA_W (192) | Write data, port w at bits [w*DATA_W +: DATA_W] |
| raddr_i | input | NUM_RD*ADDR_W (50) | Read addresses, port r at bits [r*ADDR_W +: ADDR_W] |
| rdata_o | output | NUM_RD*DATA_W (320) | Read data, port r at bits [r*DATA_W +: DATA_W] |

## Verification
The bench builds the block with its default parameters: 32 entries of 32 bits, ten read ports, six write ports and a 2-bit low predecode group. With six writers, all of them can be aimed at one entry in a single cycle, so every rank of the write priority is exercised. With ten readers, a single cycle can sample the forwarded word on some ports and stored words on the others. With 32 entries, a handful of cycles of six-wide writes covers every wordline, and the full low-by-high product of the two predecode groups can be walked.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ENTRIES  = 32;
  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_NUM_RD   = 10;
  localparam int unsigned RF_NUM_WR   = 6;
  localparam int unsigned RF_PRE_LO_W = 2;
endpackage

// File: rtl/rf_predecode.sv
// Two-level decode: group predecode, then AND of one line per group.
module rf_predecode #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LO_W   = 2,
  localparam int unsigned HI_W  = ADDR_W - LO_W,
  localparam int unsigned LO_N  = 1 << LO_W,
  localparam int unsigned HI_N  = 1 << HI_W,
  localparam int unsigned N_WL  = LO_N * HI_N
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_WL-1:0]   wl_o
);
  logic [LO_N-1:0] pre_lo;
  logic [HI_N-1:0] pre_hi;

  always_comb begin
    pre_lo = '0;
    pre_lo[addr_i[LO_W-1:0]] = 1'b1;
  end

  always_comb begin
    pre_hi = '0;
    pre_hi[addr_i[ADDR_W-1:LO_W]] = 1'b1;
  end

  for (genvar e = 0; e < N_WL; e++) begin : g_wl
    assign wl_o[e] = pre_lo[e % LO_N] & pre_hi[e / LO_N];
  end
endmodule

// File: rtl/rf_write_arb.sv
// Per-entry write select; later (higher) ports override earlier ones.
module rf_write_arb #(
  parameter int unsigned NUM_WR  = 6,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [NUM_WR-1:0]  we_i,
  input  logic [ENTRIES-1:0] wl_i [NUM_WR],
  input  logic [DATA_W-1:0]  wdata_i [NUM_WR],
  output logic [ENTRIES-1:0] ent_hit_o,
  output logic [DATA_W-1:0]  ent_wdata_o [ENTRIES]
);
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      ent_hit_o[e]   = 1'b0;
      ent_wdata_o[e] = '0;
      for (int w = 0; w < NUM_WR; w++) begin
        if (we_i[w] && wl_i[w][e]) begin
          ent_hit_o[e]   = 1'b1;
          ent_wdata_o[e] = wdata_i[w];
        end
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
// One read port: wordline-selected cell (inverted back) or forwarded data.
module rf_read_port #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [ENTRIES-1:0] rwl_i,
  input  logic [DATA_W-1:0]  cell_n_i [ENTRIES],
  input  logic [ENTRIES-1:0] ent_hit_i,
  input  logic [DATA_W-1:0]  ent_wdata_i [ENTRIES],
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] sel_cell_n;
  logic [DATA_W-1:0] sel_fwd;
  logic              sel_hit;

  always_comb begin
    sel_cell_n = '0;
    sel_fwd    = '0;
    sel_hit    = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      sel_cell_n = sel_cell_n | ({DATA_W{rwl_i[e]}} & cell_n_i[e]);
      sel_fwd    = sel_fwd    | ({DATA_W{rwl_i[e]}} & ent_wdata_i[e]);
      sel_hit    = sel_hit    | (rwl_i[e] & ent_hit_i[e]);
    end
  end

  assign rdata_o = sel_hit ? sel_fwd : ~sel_cell_n;
endmodule

// File: rtl/rf_mp_top.sv
module rf_mp_top
  import rf_pkg::*;
#(
  parameter int unsigned ENTRIES  = RF_ENTRIES,
  parameter int unsigned DATA_W   = RF_DATA_W,
  parameter int unsigned NUM_RD   = RF_NUM_RD,
  parameter int unsigned NUM_WR   = RF_NUM_WR,
  parameter int unsigned PRE_LO_W = RF_PRE_LO_W,
  localparam int unsigned ADDR_W  = $clog2(ENTRIES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_WR-1:0]          we_i,
  input  logic [NUM_WR*ADDR_W-1:0]   waddr_i,
  input  logic [NUM_WR*DATA_W-1:0]   wdata_i,
  input  logic [NUM_RD*ADDR_W-1:0]   raddr_i,
  output logic [NUM_RD*DATA_W-1:0]   rdata_o
);
  logic [ENTRIES-1:0] wwl [NUM_WR];
  logic [ENTRIES-1:0] rwl [NUM_RD];
  logic [DATA_W-1:0]  wdata [NUM_WR];
  logic [ENTRIES-1:0] ent_hit;
  logic [DATA_W-1:0]  ent_wdata [ENTRIES];
  logic [DATA_W-1:0]  cell_n_q [ENTRIES];

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wdec
    assign wdata[w] = wdata_i[w*DATA_W +: DATA_W];
    rf_predecode #(.ADDR_W(ADDR_W), .LO_W(PRE_LO_W)) u_dec (
      .addr_i (waddr_i[w*ADDR_W +: ADDR_W]),
      .wl_o   (wwl[w])
    );
    // R8: every write address drives exactly one wordline
    a_r8_wwl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(wwl[w]) == 1);
  end

  rf_write_arb #(.NUM_WR(NUM_WR), .ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_arb (
    .we_i        (we_i),
    .wl_i        (wwl),
    .wdata_i     (wdata),
    .ent_hit_o   (ent_hit),
    .ent_wdata_o (ent_wdata)
  );

  // Storage holds the complement; reset sets all cells so entries read zero.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cell_n_q[e] <= '1;
      else if (ent_hit[e]) cell_n_q[e] <= ~ent_wdata[e];
    end
    a_r9_cell_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_hit[e] |=> cell_n_q[e] == ~$past(ent_wdata[e]));
    a_r7_cell_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ent_hit[e] |=> $stable(cell_n_q[e]));
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;

    rf_predecode #(.ADDR_W(ADDR_W), .LO_W(PRE_LO_W)) u_dec (
      .addr_i (raddr_i[r*ADDR_W +: ADDR_W]),
      .wl_o   (rwl[r])
    );

    rf_read_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd (
      .rwl_i       (rwl[r]),
      .cell_n_i    (cell_n_q),
      .ent_hit_i   (ent_hit),
      .ent_wdata_i (ent_wdata),
      .rdata_o     (rdata_o[r*DATA_W +: DATA_W])
    );

    // Address-compare view of forwarding, independent of the wordline path.
    always_comb begin
      fwd_hit  = 1'b0;
      fwd_data = '0;
      for (int w = 0; w < NUM_WR; w++) begin
        if (we_i[w] && waddr_i[w*ADDR_W +: ADDR_W] == raddr_i[r*ADDR_W +: ADDR_W]) begin
          fwd_hit  = 1'b1;
          fwd_data = wdata_i[w*DATA_W +: DATA_W];
        end
      end
    end

    a_r4_fwd_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_hit |-> rdata_o[r*DATA_W +: DATA_W] == fwd_data);
    a_r8_rwl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rwl[r]) == 1);
  end
endmodule

// File: tb/rf_mp_top_tb.sv
module rf_mp_top_tb_top;
  localparam int unsigned ENT = 32;
  localparam int unsigned DW  = 32;
  localparam int unsigned NR  = 10;
  localparam int unsigned NW  = 6;
  localparam int unsigned AW  = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0]    we_i;
  logic [NW*AW-1:0] waddr_i;
  logic [NW*DW-1:0] wdata_i;
  logic [NR*AW-1:0] raddr_i;
  logic [NR*DW-1:0] rdata_o;

  logic [NW-1:0] we_b;
  logic [AW-1:0] wa_b [NW];
  logic [DW-1:0] wd_b [NW];
  logic [AW-1:0] ra_b [NR];
  logic [DW-1:0] ref_mem [ENT];

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  always_comb begin
    we_i = we_b;
    for (int w = 0; w < NW; w++) begin
      waddr_i[w*AW +: AW] = wa_b[w];
      wdata_i[w*DW +: DW] = wd_b[w];
    end
    for (int r = 0; r < NR; r++) raddr_i[r*AW +: AW] = ra_b[r];
  end

  rf_mp_top dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .raddr_i (raddr_i),
    .rdata_o (rdata_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = ref_mem[a];
    for (int w = 0; w < NW; w++)
      if (we_b[w] && wa_b[w] == a) v = wd_b[w];
    return v;
  endfunction

  task automatic clear_inputs();
    we_b = '0;
    for (int w = 0; w < NW; w++) begin wa_b[w] = '0; wd_b[w] = '0; end
    for (int r = 0; r < NR; r++) ra_b[r] = '0;
  endtask

  // Inputs set at negedge; check mid-low phase; model commits with the edge.
  task automatic cycle(input string tag);
    logic [DW-1:0] exp, got;
    #1;
    for (int r = 0; r < NR; r++) begin
      exp = exp_read(ra_b[r]);
      got = rdata_o[r*DW +: DW];
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s port %0d addr %0d got %h exp %h", tag, r, ra_b[r], got, exp);
      end
    end
    for (int w = 0; w < NW; w++)
      if (we_b[w]) ref_mem[wa_b[w]] = wd_b[w];
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    clear_inputs();
    for (int e = 0; e < ENT; e++) ref_mem[e] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: everything reads zero after reset
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < NR; r++) ra_b[r] = AW'((k*NR + r) % ENT);
      cycle("R1");
    end

    // R8: walk every wordline with distinct values, then read all back
    for (int c = 0; c < 6; c++) begin
      clear_inputs();
      for (int w = 0; w < NW; w++) begin
        if (c*NW + w < ENT) begin
          we_b[w] = 1'b1;
          wa_b[w] = AW'(c*NW + w);
          wd_b[w] = 32'hA500_0000 | (32'(c*NW + w) << 8) | 32'(c*NW + w);
        end
      end
      for (int r = 0; r < NR; r++) ra_b[r] = AW'($urandom % ENT);
      cycle("R8");
    end
    clear_inputs();
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < NR; r++) ra_b[r] = AW'((k*NR + r) % ENT);
      cycle("R8");
    end

    // R3: same-cycle forwarding to several readers
    clear_inputs();
    we_b[0] = 1'b1; wa_b[0] = 5'd7; wd_b[0] = $urandom;
    we_b[3] = 1'b1; wa_b[3] = 5'd30; wd_b[3] = $urandom;
    for (int r = 0; r < NR; r++) ra_b[r] = (r % 3 == 0) ? 5'd7 : ((r % 3 == 1) ? 5'd30 : 5'd8);
    cycle("R3");

    // R4: all six ports collide on one entry
    clear_inputs();
    for (int w = 0; w < NW; w++) begin
      we_b[w] = 1'b1; wa_b[w] = 5'd12; wd_b[w] = 32'h1111_1111 * 32'(w + 1);
    end
    for (int r = 0; r < NR; r++) ra_b[r] = (r % 2 == 0) ? 5'd12 : AW'(r);
    cycle("R4");
    clear_inputs();
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd12;
    cycle("R4");
    // R4: two enabled ports collide; a disabled higher port must not win
    clear_inputs();
    we_b[1] = 1'b1; wa_b[1] = 5'd20; wd_b[1] = 32'hDEAD_0001;
    we_b[4] = 1'b1; wa_b[4] = 5'd20; wd_b[4] = 32'hBEEF_0004;
    we_b[5] = 1'b0; wa_b[5] = 5'd20; wd_b[5] = 32'hCAFE_0005;
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd20;
    cycle("R4");
    clear_inputs();
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd20;
    cycle("R4");

    // R5: disabled ports aimed at a live entry
    clear_inputs();
    for (int w = 0; w < NW; w++) begin wa_b[w] = 5'd3; wd_b[w] = $urandom; end
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd3;
    cycle("R5");
    clear_inputs();
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd3;
    cycle("R5");

    // R6: all readers on one entry, and readers spread out
    clear_inputs();
    for (int r = 0; r < NR; r++) ra_b[r] = 5'd17;
    cycle("R6");
    for (int r = 0; r < NR; r++) ra_b[r] = AW'(31 - r);
    cycle("R6");

    // R9: extreme patterns survive complemented storage
    clear_inputs();
    we_b[2] = 1'b1; wa_b[2] = 5'd9;  wd_b[2] = 32'hFFFF_FFFF;
    we_b[5] = 1'b1; wa_b[5] = 5'd10; wd_b[5] = 32'h0000_0000;
    for (int r = 0; r < NR; r++) ra_b[r] = (r < 5) ? 5'd9 : 5'd10;
    cycle("R9");
    clear_inputs();
    for (int r = 0; r < NR; r++) ra_b[r] = (r < 5) ? 5'd9 : 5'd10;
    cycle("R9");

    // R2: random multi-port traffic with conflicts and read-during-write
    for (int n = 0; n < 400; n++) begin
      for (int w = 0; w < NW; w++) begin
        we_b[w] = ($urandom % 3) != 0;
        wa_b[w] = ($urandom % 4 == 0) ? 5'd5 : AW'($urandom % ENT);
        wd_b[w] = $urandom;
      end
      for (int r = 0; r < NR; r++)
        ra_b[r] = ($urandom % 3 == 0) ? wa_b[$urandom % NW] : AW'($urandom % ENT);
      cycle("R2");
    end

    // R7: idle cycles, contents must hold
    clear_inputs();
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < NR; r++) ra_b[r] = AW'((k*NR + r) % ENT);
      cycle("R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule